// File: doc/BRIEF.md
# Accumulator CPU timing-step control

This block is a 16-bit accumulator processor with a 12-bit word address space. A 3-bit sequence counter walks through timing states T0 to T6. Control strobes are formed from a one-hot opcode decode combined with the current state. Every instruction follows a fixed register-transfer schedule, and its last state clears the counter. The datapath holds a program counter, an address register, an instruction register, a data register, the accumulator, a carry flag, an indirect flag and a run flag.

The block drives a synchronous word memory with one cycle of read latency. A read is requested one state before its data is consumed. For that reason the address bus carries the value the address register is about to take, not the value it holds. Memory-reference opcodes form an alternate set: exclusive-OR, add-to-memory, subtract, exchange, skip-if-equal and branch-if-positive. The only register-reference instruction supported is halt.

Top module: `acpu_core`

## Requirements
- R1: While reset is low, PC equals `start_addr_i`, AC is 0, E is 0 and `run_o` is 1. The first state after reset issues a read at `start_addr_i`.
- R2: An instruction word holds the indirect bit in bit 15, the opcode in bits 14:12 and the address in bits 11:0. T0 reads the word at PC, T1 loads IR and increments PC, and T2 loads AR from the address field.
- R3: With bit 15 set and an opcode other than 111, T3 replaces AR with the memory word at AR (low 12 bits). Indirect instructions take the same number of cycles as direct ones.
- R4: Opcode 000 sets AC to AC xor M[EA] and finishes at T5.
- R5: Opcode 001 writes M[EA]+AC back to M[EA] at T6 and sets E to the carry-out. AC is unchanged. Adding 0xFFE9 and 0x0053 leaves 0x003C with E=1.
- R6: Opcode 010 sets AC to AC−M[EA] modulo 2^16 and sets E to 1 when AC ≥ M[EA] unsigned (no borrow). It finishes at T5.
- R7: Opcode 011 exchanges AC and M[EA]. DR is loaded at T4, and at T5 memory is written with the old AC while AC takes DR.
- R8: Opcode 100 increments PC once more at T5 when M[EA] equals AC.
- R9: Opcode 101 loads PC with EA at T4 when AC is positive and non-zero. With AC zero or negative, PC is unchanged.
- R10: Word 0x7001 (opcode 111, bit 15 clear, bit 0 set) clears the run flag at T3. After that, no memory strobe is issued and PC, AC and E hold.
- R11: A full instruction takes, counting fetch, 5 cycles for opcode 101, 7 for opcode 001 and 6 for opcodes 000, 010, 011 and 100. Writes occur only in the final state, and `mem_en_o` accompanies every read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_addr_i | input | 12 | PC value loaded by reset |
| mem_en_o | output | 1 | Memory access enable |
| mem_rd_o | output | 1 | Read request; data valid on `mem_rdata_i` in the next cycle |
| mem_wr_o | output | 1 | Write request, committed at the clock edge |
| mem_addr_o | output | 12 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after the request |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| pc_o | output | 12 | Program counter |
| run_o | output | 1 | Run flag; low after halt |

## Verification
The bench sweeps each of the six memory-reference opcodes over a grid of operand pairs. The pairs include zero, one, both sign extremes, all ones and the 0x0053/0xFFE9 carry case, and the bench computes the expected AC, E, memory word and PC arithmetically. Several faults would show up in these sweeps:
- A swapped subtract operand or an inverted borrow sense corrupts AC or E whenever the operands differ.
- A branch test that treats zero or 0x8000 as positive lands on the wrong halt address.
- A skip comparator that is off causes a missed or a spurious skip.
- An exchange that latches the new AC before writing memory stores the wrong word.

Cycle counts to halt expose a sequence counter cleared one state early or late. An indirect exchange catches effective-address mistakes. Idle cycles after halt catch strobes that leak while stopped.

// File: rtl/acpu_pkg.sv
package acpu_pkg;
  parameter int unsigned DW    = 16;
  parameter int unsigned AW    = 12;
  parameter int unsigned OPW   = 3;
  parameter int unsigned NUM_T = 7;
  localparam int unsigned SCW  = $clog2(NUM_T);
  localparam int unsigned NUM_D = 1 << OPW;

  typedef enum logic [OPW-1:0] {
    OP_XOR = 3'd0, OP_ADM = 3'd1, OP_SUB = 3'd2, OP_XCH = 3'd3,
    OP_SEQ = 3'd4, OP_BPA = 3'd5, OP_NOP = 3'd6, OP_REG = 3'd7
  } op_e;

  typedef struct packed {
    logic ar_pc;
    logic ar_ir;
    logic ar_mem;
    logic ir_ld;
    logic i_ld;
    logic pc_inc;
    logic pc_ar;
    logic dr_ld;
    logic dr_add;
    logic ac_xor;
    logic ac_sub;
    logic ac_dr;
    logic e_add;
    logic e_sub;
    logic s_clr;
    logic sc_clr;
    logic mem_rd;
    logic mem_wr;
    logic wsel_dr;
  } ctl_t;
endpackage

// File: rtl/acpu_timing.sv
module acpu_timing
  import acpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             sc_clr_i,
  output logic [NUM_T-1:0] t_o
);
  logic [SCW-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sc_q <= '0;
    else if (sc_clr_i || !run_i) sc_q <= '0;
    else                        sc_q <= sc_q + SCW'(1);
  end

  for (genvar k = 0; k < NUM_T; k++) begin : g_tdec
    assign t_o[k] = (sc_q == SCW'(k));
  end

  AST_SC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_q < SCW'(NUM_T)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sc_q == '0)); // R10
endmodule

// File: rtl/acpu_ctrl.sv
module acpu_ctrl
  import acpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_T-1:0] t_i,
  input  logic [DW-1:0]    ir_i,
  input  logic             i_i,
  input  logic             s_i,
  input  logic             ac_pos_i,
  input  logic             dr_eq_ac_i,
  output ctl_t             ctl_o
);
  logic [NUM_D-1:0] d;
  logic             rd_op, hlt;
  ctl_t             c;

  for (genvar k = 0; k < NUM_D; k++) begin : g_ddec
    assign d[k] = (ir_i[DW-2 -: OPW] == OPW'(k));
  end

  assign rd_op = d[OP_XOR] | d[OP_ADM] | d[OP_SUB] | d[OP_XCH] | d[OP_SEQ];
  assign hlt   = d[OP_REG] & ~i_i & ir_i[0];

  always_comb begin
    c = '0;
    // fetch / decode
    c.ar_pc   = t_i[0];
    c.mem_rd  = t_i[0];
    c.ir_ld   = t_i[1];
    c.pc_inc  = t_i[1];
    c.ar_ir   = t_i[2];
    c.i_ld    = t_i[2];
    if (t_i[2] && !d[OP_REG] && ir_i[DW-1]) c.mem_rd = 1'b1; // indirect pointer read
    // T3: indirect, operand read request, register group
    if (t_i[3]) begin
      c.ar_mem = ~d[OP_REG] & i_i;
      if (rd_op) c.mem_rd = 1'b1;
      if (d[OP_REG]) begin
        c.sc_clr = 1'b1;
        c.s_clr  = hlt;
      end
    end
    if (t_i[4]) begin
      c.dr_ld = rd_op;
      if (d[OP_BPA]) c.pc_ar = ac_pos_i;
      if (d[OP_BPA] || d[OP_NOP]) c.sc_clr = 1'b1;
    end
    if (t_i[5]) begin
      c.ac_xor = d[OP_XOR];
      c.dr_add = d[OP_ADM];
      c.e_add  = d[OP_ADM];
      c.ac_sub = d[OP_SUB];
      c.e_sub  = d[OP_SUB];
      c.ac_dr  = d[OP_XCH];
      c.mem_wr = d[OP_XCH];
      if (d[OP_SEQ]) c.pc_inc = dr_eq_ac_i;
      c.sc_clr = d[OP_XOR] | d[OP_SUB] | d[OP_XCH] | d[OP_SEQ];
    end
    if (t_i[6] && d[OP_ADM]) begin
      c.mem_wr  = 1'b1;
      c.wsel_dr = 1'b1;
      c.sc_clr  = 1'b1;
    end
    if (!s_i) c = '0;
  end

  assign ctl_o = c;

  AST_WR_FINAL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.mem_wr |-> ctl_o.sc_clr); // R11
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_o.mem_rd && ctl_o.mem_wr)); // R11
endmodule

// File: rtl/acpu_datapath.sv
module acpu_datapath
  import acpu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] start_addr_i,
  input  ctl_t          ctl_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] ar_nxt_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] ir_o,
  output logic          i_o,
  output logic          s_o,
  output logic          ac_pos_o,
  output logic          dr_eq_ac_o,
  output logic [DW-1:0] ac_o,
  output logic          e_o,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q, ar_q;
  logic [DW-1:0] ir_q, dr_q, ac_q;
  logic          e_q, i_q, s_q;
  logic [DW:0]   sum, diff;

  assign sum  = {1'b0, dr_q} + {1'b0, ac_q};
  assign diff = {1'b0, ac_q} + {1'b0, ~dr_q} + (DW+1)'(1);

  always_comb begin
    ar_nxt_o = ar_q;
    if (ctl_i.ar_pc)       ar_nxt_o = pc_q;
    else if (ctl_i.ar_ir)  ar_nxt_o = ir_q[AW-1:0];
    else if (ctl_i.ar_mem) ar_nxt_o = mem_rdata_i[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= start_addr_i;
      ar_q <= '0;
      ir_q <= '0;
      dr_q <= '0;
      ac_q <= '0;
      e_q  <= 1'b0;
      i_q  <= 1'b0;
      s_q  <= 1'b1;
    end else begin
      ar_q <= ar_nxt_o;
      if (ctl_i.ir_ld)  ir_q <= mem_rdata_i;
      if (ctl_i.i_ld)   i_q  <= ir_q[DW-1];
      if (ctl_i.pc_inc) pc_q <= pc_q + AW'(1);
      else if (ctl_i.pc_ar) pc_q <= ar_q;
      if (ctl_i.dr_ld)       dr_q <= mem_rdata_i;
      else if (ctl_i.dr_add) dr_q <= sum[DW-1:0];
      if (ctl_i.ac_xor)      ac_q <= ac_q ^ dr_q;
      else if (ctl_i.ac_sub) ac_q <= diff[DW-1:0];
      else if (ctl_i.ac_dr)  ac_q <= dr_q;
      if (ctl_i.e_add)       e_q <= sum[DW];
      else if (ctl_i.e_sub)  e_q <= diff[DW];
      if (ctl_i.s_clr)       s_q <= 1'b0;
    end
  end

  assign wdata_o    = ctl_i.wsel_dr ? dr_q : ac_q;
  assign ir_o       = ir_q;
  assign i_o        = i_q;
  assign s_o        = s_q;
  assign ac_pos_o   = ~ac_q[DW-1] & (ac_q != '0);
  assign dr_eq_ac_o = (dr_q == ac_q);
  assign ac_o       = ac_q;
  assign e_o        = e_q;
  assign pc_o       = pc_q;

  AST_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_q |=> $stable(pc_q) && $stable(ac_q) && $stable(e_q)); // R10
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_q |=> !s_q); // R10
  AST_IR_LOAD_T1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ir_q) |-> $past(ctl_i.ir_ld)); // R2
endmodule

// File: rtl/acpu_core.sv
module acpu_core
  import acpu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] start_addr_i,
  output logic          mem_en_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] ac_o,
  output logic          e_o,
  output logic [AW-1:0] pc_o,
  output logic          run_o
);
  ctl_t             ctl;
  logic [NUM_T-1:0] t;
  logic [DW-1:0]    ir;
  logic             i_f, s_f, ac_pos, dr_eq_ac;

  acpu_timing u_timing (
    .clk_i, .rst_ni, .run_i(s_f), .sc_clr_i(ctl.sc_clr), .t_o(t)
  );

  acpu_ctrl u_ctrl (
    .clk_i, .rst_ni, .t_i(t), .ir_i(ir), .i_i(i_f), .s_i(s_f),
    .ac_pos_i(ac_pos), .dr_eq_ac_i(dr_eq_ac), .ctl_o(ctl)
  );

  acpu_datapath u_dp (
    .clk_i, .rst_ni, .start_addr_i, .ctl_i(ctl), .mem_rdata_i,
    .ar_nxt_o(mem_addr_o), .wdata_o(mem_wdata_o), .ir_o(ir), .i_o(i_f),
    .s_o(s_f), .ac_pos_o(ac_pos), .dr_eq_ac_o(dr_eq_ac), .ac_o, .e_o, .pc_o
  );

  assign mem_rd_o = ctl.mem_rd;
  assign mem_wr_o = ctl.mem_wr;
  assign mem_en_o = ctl.mem_rd | ctl.mem_wr;
  assign run_o    = s_f;

  AST_EN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> mem_en_o); // R11
  AST_NO_STROBE_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> !mem_en_o); // R10
endmodule

// File: tb/tb_acpu_core.sv
module tb_acpu_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] start_addr = 12'h100;
  logic        mem_en, mem_rd, mem_wr, e, run;
  logic [11:0] addr, pc;
  logic [15:0] wdata, ac;
  logic [15:0] rdata = '0;
  logic [15:0] mem [0:4095];
  int n_chk = 0, n_fail = 0, cyc = 0, halt_strobes = 0;

  always #4ns clk = ~clk;

  acpu_core dut (
    .clk_i(clk), .rst_ni, .start_addr_i(start_addr), .mem_en_o(mem_en),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .ac_o(ac), .e_o(e),
    .pc_o(pc), .run_o(run)
  );

  always @(posedge clk) begin
    if (mem_en && mem_wr) mem[addr] <= wdata;
    if (mem_en && mem_rd) rdata <= mem[addr];
    if (rst_ni && !run && mem_en) halt_strobes++;
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 4096; k++) mem[k] = '0;
  endtask

  // resets, runs until halt; returns cycles counted from release
  task automatic run_prog(output int cycles);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    cycles = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cycles++;
      if (!run) break;
    end
    if (run) check("R10 halt reached", 0, 1);
  endtask

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                       16'hFFFF, 16'h0053, 16'hFFE9, 16'h1234};

  initial begin
    int cycles;
    logic [16:0] s17;
    clear_mem();
    // R1 reset state
    @(negedge clk);
    check("R1 pc", pc, 12'h100);
    check("R1 ac", ac, 0);
    check("R1 e", e, 0);
    check("R1 run", run, 1);
    rst_ni = 1'b1;
    check("R1 first fetch addr", {mem_rd, addr}, {1'b1, 12'h100});
    check("R2 fetch enable", mem_en, 1);

    // sweep all six opcodes over operand grid
    for (int op = 0; op < 6; op++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int im = 0; im < 8; im++) begin
          logic [15:0] a, m, exp_ac, exp_m;
          logic [11:0] exp_pc;
          logic        exp_e;
          int          exp_n;
          a = VALS[ia]; m = VALS[im];
          clear_mem();
          mem[12'h100] = 16'h3200;                       // exchange: AC <- a
          mem[12'h101] = (op == 5) ? 16'h5180 : 16'({op[2:0], 12'h201});
          mem[12'h102] = 16'h7001;
          mem[12'h103] = 16'h7001;
          mem[12'h180] = 16'h7001;
          mem[12'h200] = a;
          mem[12'h201] = m;
          run_prog(cycles);
          exp_ac = a; exp_m = m; exp_e = 1'b0; exp_pc = 12'h103; exp_n = 6;
          case (op)
            0: exp_ac = a ^ m;
            1: begin s17 = {1'b0, a} + {1'b0, m}; exp_m = s17[15:0]; exp_e = s17[16]; exp_n = 7; end
            2: begin exp_ac = a - m; exp_e = (a >= m); end
            3: begin exp_ac = m; exp_m = a; end
            4: if (a == m) exp_pc = 12'h104;
            default: begin exp_n = 5; if (!a[15] && a != 0) exp_pc = 12'h181; end
          endcase
          case (op)
            0: check("R4 xor ac", ac, exp_ac);
            1: begin check("R5 adm mem", mem[12'h201], exp_m); check("R5 adm e", e, exp_e);
                     check("R5 adm ac", ac, exp_ac); end
            2: begin check("R6 sub ac", ac, exp_ac); check("R6 sub e", e, exp_e); end
            3: begin check("R7 xch ac", ac, exp_ac); check("R7 xch mem", mem[12'h201], exp_m);
                     check("R7 xch old ac", mem[12'h200], 0); end
            4: check("R8 seq pc", pc, exp_pc);
            default: check("R9 bpa pc", pc, exp_pc);
          endcase
          if (ia == 0 && im == 0 || ia == 5 && im == 6)
            check("R11 cycles to halt", cycles, 10 + exp_n);
        end
      end
    end

    // R5 named carry case
    clear_mem();
    mem[12'h100] = 16'h3200; mem[12'h101] = 16'h1201; mem[12'h102] = 16'h7001;
    mem[12'h200] = 16'h0053; mem[12'h201] = 16'hFFE9;
    run_prog(cycles);
    check("R5 0053+FFE9", {15'd0, e, mem[12'h201]}, {15'd0, 1'b1, 16'h003C});

    // R3 indirect exchange, then indirect add
    clear_mem();
    mem[12'h100] = 16'hB300; mem[12'h101] = 16'h9301; mem[12'h102] = 16'h7001;
    mem[12'h300] = 16'h0250; mem[12'h250] = 16'hABCD;
    mem[12'h301] = 16'h0260; mem[12'h260] = 16'h1111;
    run_prog(cycles);
    check("R3 indirect xch ac", ac, 16'hABCD);
    check("R3 indirect xch mem", mem[12'h250], 16'h0000);
    check("R3 indirect adm mem", mem[12'h260], 16'hBCDE);
    check("R3 pointer intact", mem[12'h300], 16'h0250);
    check("R3 indirect cycles", cycles, 6 + 7 + 4);

    // R10 halted: idle, no strobes, state holds
    halt_strobes = 0;
    repeat (30) @(negedge clk);
    check("R10 no strobes halted", halt_strobes, 0);
    check("R10 pc held", pc, 12'h103);
    check("R10 ac held", ac, 16'hABCD);
    check("R10 run low", run, 0);

    // R2 start address honored elsewhere
    start_addr = 12'h7F0;
    clear_mem();
    mem[12'h7F0] = 16'h7001;
    run_prog(cycles);
    check("R2 halt pc from start", pc, 12'h7F1);
    check("R10 halt cycles", cycles, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule